// File: doc/BRIEF.md
# Pipelined ADC Conversion Sequencer

This block controls the timing of a sampling converter entirely in the system-clock domain. A slow conversion clock arrives as an ordinary input. It is synchronized and edge-detected. Each accepted rising edge launches one conversion, and the digital sample word that stands in for the analog level is captured on that same cycle. The result appears on the data output a fixed number of system cycles after the launch. Every time the output changes, the valid strobe goes low for a configurable number of cycles.

Several conversions can be in flight at once, and each one has its own countdown slot. Results leave in the order their conversions started. A rising edge that comes too soon after the last accepted launch is dropped without trace. By default the output word is in offset binary. A parameter switches it to two's complement, which is offset binary with the top bit inverted. If a parameter set breaks the rule that the minimum spacing is shorter than the latency, elaboration reports an error.

Top module: `conv_sequencer`

## Requirements
- R1: A rising edge of `conv_clk` that is first seen high at system edge c launches a conversion at edge c+2, provided R4 allows it. The word on `sample_in` at that launch edge is the one converted.
- R2: `data_out` takes a new value exactly LATENCY system edges after a launch edge and holds its value on every other edge.
- R3: `data_valid` goes low on the same edge that `data_out` updates. It stays low for DV_LOW cycles and is high at all other times. An update that arrives while it is low restarts the low interval.
- R4: A launch candidate is accepted only when more than MIN_GAP edges have passed since the previous accepted launch. A rejected candidate never changes any output, and it does not restart the spacing interval.
- R5: Overlapping conversions each deliver their own captured sample, in launch order.
- R6: Launches back to back at the minimum legal spacing never lose or corrupt a conversion.
- R7: With CODING = CODE_OFFSET, the captured word is output unchanged. With CODING = CODE_TWOS, bit DATA_W-1 is inverted and the other bits are unchanged.
- R8: While `rst_n` is low on an edge, every conversion in flight is discarded, `data_out` is zero and `data_valid` is high. No discarded conversion appears after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_clk | input | 1 | Conversion clock; its rising edges request a launch |
| sample_in | input | DATA_W | Sample word captured at launch |
| data_out | output | DATA_W | Converted result |
| data_valid | output | 1 | Low for DV_LOW cycles after each result update |

## Verification
A slot that is freed early, or a timer that is off by one, shows at the ports as a `data_out` update one cycle early or late. It appears LATENCY cycles after the faulty launch, together with a valid low pulse at the wrong time. A spacing counter that is wrong shows as an extra or a missing update within about LATENCY cycles of a burst of closely spaced edges. A wrong read pointer shows as samples delivered out of order during overlap. The bench tracks every cycle against an arithmetic model, so each such fault is caught on the first wrong edge.

// File: rtl/conv_seq_pkg.sv
// Shared types and helpers for the conversion sequencer.
package conv_seq_pkg;

    // Output coding selection.
    typedef enum logic {
        CODE_OFFSET = 1'b0,
        CODE_TWOS   = 1'b1
    } code_e;

    // Number of in-flight slots needed for a latency and a minimum spacing.
    function automatic int slots_needed(input int lat, input int gap);
        return (lat + gap - 1) / gap;
    endfunction

endpackage

// File: rtl/conv_edge_sync.sv
// Brings the conversion clock into the system domain and produces a
// one-cycle pulse for each rising edge.
// Assumes: the conversion clock is slow enough that each level is seen
// for at least one system cycle.
module conv_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [2:0] shift_q;

    // Two synchronizing stages plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[1:0], async_in};
    end

    assign rise_o = shift_q[1] & ~shift_q[2];

    // R1: an edge pulse lasts one cycle only
    p_rise_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/conv_start_gate.sv
// Passes a launch request only if more than MIN_GAP cycles have elapsed
// since the last accepted launch. Rejected requests leave no state behind.
// Assumes: MIN_GAP >= 1.
module conv_start_gate #(
    parameter int MIN_GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    output logic accept_o
);
    localparam int CW = $clog2(MIN_GAP + 2);
    localparam logic [CW-1:0] GAP_V = CW'(MIN_GAP);
    localparam logic [CW-1:0] SAT_V = CW'(MIN_GAP + 1);

    logic [CW-1:0] since_q;

    assign accept_o = rise_i && (since_q > GAP_V);

    // Count cycles since the last accepted launch, saturating once it is legal again.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_q <= SAT_V;
        else if (accept_o)       since_q <= CW'(1);
        else if (since_q != SAT_V) since_q <= since_q + 1'b1;
    end

    // R4: two launches are never accepted on adjacent cycles
    p_gap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !accept_o);
endmodule

// File: rtl/conv_slot_pipe.sv
// A ring of in-flight conversion slots. Each slot holds its captured word
// and counts down the latency on its own. Slots retire in launch order.
// Assumes: launches are spaced so that at most NSLOT are in flight.
module conv_slot_pipe #(
    parameter int DATA_W  = 8,
    parameter int LATENCY = 12,
    parameter int NSLOT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              done_o,
    output logic [DATA_W-1:0] word_o
);
    localparam int TW = $clog2(LATENCY);
    localparam int PW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam logic [TW-1:0] TLOAD = TW'(LATENCY - 1);

    logic [NSLOT-1:0]  busy;
    logic [NSLOT-1:0]  done_vec;
    logic [DATA_W-1:0] dat [NSLOT];
    logic [PW-1:0]     wr_ptr, rd_ptr;

    // Advance a ring pointer with wrap.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(NSLOT - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic              busy_q;
        logic [TW-1:0]     tmr_q;
        logic [DATA_W-1:0] dat_q;

        assign busy[i]     = busy_q;
        assign dat[i]      = dat_q;
        assign done_vec[i] = busy_q && (tmr_q == '0);

        // Load on launch, count down while busy, free on retire.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q <= 1'b0;
                tmr_q  <= '0;
                dat_q  <= '0;
            end else if (start_i && wr_ptr == PW'(i)) begin
                busy_q <= 1'b1;
                tmr_q  <= TLOAD;
                dat_q  <= sample_i;
            end else if (done_vec[i] && rd_ptr == PW'(i)) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                tmr_q  <= tmr_q - 1'b1;
            end
        end
    end

    assign done_o = done_vec[rd_ptr];
    assign word_o = dat[rd_ptr];

    // Move write pointer on launch and read pointer on retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (start_i) wr_ptr <= bump(wr_ptr);
            if (done_o)  rd_ptr <= bump(rd_ptr);
        end
    end

    // R6: a launch never lands on an occupied slot
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy[wr_ptr]);
    // R5: only the oldest slot can finish
    p_retire_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_vec) |-> done_vec[rd_ptr]);
    // R5: at most one slot finishes per cycle
    p_single_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_vec));
endmodule

// File: rtl/conv_out_stage.sv
// Applies the output coding, registers the result and shapes the valid
// strobe low for DV_LOW cycles after each update.
// Assumes: DV_LOW >= 1.
module conv_out_stage
    import conv_seq_pkg::*;
#(
    parameter int    DATA_W = 8,
    parameter int    DV_LOW = 3,
    parameter code_e CODING = CODE_OFFSET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    localparam int DVW = $clog2(DV_LOW + 1);
    localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] coded;
    logic [DVW-1:0]    low_q;

    if (CODING == CODE_TWOS) begin : g_twos
        assign coded = word_i ^ MSB_MASK;
    end else begin : g_offset
        assign coded = word_i;
    end

    // Register each retired result.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_o <= '0;
        else if (done_i) data_o <= coded;
    end

    // Hold the strobe low for DV_LOW cycles after each update.
    always_ff @(posedge clk) begin
        if (!rst_n)           low_q <= '0;
        else if (done_i)      low_q <= DVW'(DV_LOW);
        else if (low_q != '0) low_q <= low_q - 1'b1;
    end

    assign valid_o = (low_q == '0);

    // R3: an update always drops the strobe on the next cycle
    p_valid_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !valid_o);
    // R2: without a retire the output holds
    p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(data_o));
endmodule

// File: rtl/conv_sequencer.sv
// Top of the conversion sequencer: edge sync, launch spacing gate,
// in-flight slot ring and output stage.
// Assumes: 1 <= MIN_GAP < LATENCY, 1 <= DATA_W <= 32, DV_LOW >= 1.
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int    DATA_W  = 8,
    parameter int    LATENCY = 12,
    parameter int    MIN_GAP = 4,
    parameter int    DV_LOW  = 3,
    parameter code_e CODING  = CODE_OFFSET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_clk,
    input  logic [DATA_W-1:0] sample_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_valid
);
    localparam int NSLOT = slots_needed(LATENCY, MIN_GAP);

    // Flag illegal parameter sets at elaboration.
    if (MIN_GAP < 1 || MIN_GAP >= LATENCY || DATA_W < 1 || DATA_W > 32 || DV_LOW < 1) begin : g_cfg_bad
        initial $error("conv_sequencer: need 1 <= MIN_GAP < LATENCY, 1 <= DATA_W <= 32, DV_LOW >= 1");
    end

    logic              rise;
    logic              launch;
    logic              retire;
    logic [DATA_W-1:0] retire_word;

    conv_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (conv_clk),
        .rise_o   (rise)
    );

    conv_start_gate #(.MIN_GAP(MIN_GAP)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (rise),
        .accept_o (launch)
    );

    conv_slot_pipe #(.DATA_W(DATA_W), .LATENCY(LATENCY), .NSLOT(NSLOT)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (launch),
        .sample_i (sample_in),
        .done_o   (retire),
        .word_o   (retire_word)
    );

    conv_out_stage #(.DATA_W(DATA_W), .DV_LOW(DV_LOW), .CODING(CODING)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (retire),
        .word_i  (retire_word),
        .data_o  (data_out),
        .valid_o (data_valid)
    );

    // R8: a reset cycle leaves the outputs idle
    p_reset_state_r8: assert property (@(posedge clk)
        !rst_n |=> (data_valid && data_out == '0));
endmodule

// File: tb/conv_sequencer_test.sv
// Self-checking bench: a cycle model built from the requirements runs
// alongside two instances (offset and two's-complement coding).
module conv_sequencer_test;
    import conv_seq_pkg::*;

    localparam int DW  = 6;
    localparam int LAT = 10;
    localparam int GAP = 3;
    localparam int DVL = 2;
    localparam int N   = 4096;
    localparam logic [DW-1:0] MSB = {1'b1, {(DW-1){1'b0}}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_clk = 1'b0;
    logic [DW-1:0] sample_in = '0;
    logic [DW-1:0] dout, dout_tc;
    logic          dv, dv_tc;

    always #10 clk = ~clk;

    conv_sequencer #(.DATA_W(DW), .LATENCY(LAT), .MIN_GAP(GAP), .DV_LOW(DVL),
                     .CODING(CODE_OFFSET)) uut (
        .clk(clk), .rst_n(rst_n), .conv_clk(conv_clk), .sample_in(sample_in),
        .data_out(dout), .data_valid(dv));

    conv_sequencer #(.DATA_W(DW), .LATENCY(LAT), .MIN_GAP(GAP), .DV_LOW(DVL),
                     .CODING(CODE_TWOS)) uut_tc (
        .clk(clk), .rst_n(rst_n), .conv_clk(conv_clk), .sample_in(sample_in),
        .data_out(dout_tc), .data_valid(dv_tc));

    int    checks = 0;
    int    fails  = 0;
    bit    finished = 1'b0;
    string tag = "R8";

    // Reference model state
    int            cyc = 0;
    bit            prev_cc = 1'b0;
    bit            pend  [N];
    bit            sched [N];
    logic [DW-1:0] sval  [N];
    int            last_acc = -100;
    logic [DW-1:0] exp_off = '0;
    logic [DW-1:0] exp_tc  = '0;
    int            dvcnt = 0;

    // Model: edge seen at c launches at c+2 (R1), spacing rule (R4),
    // update LAT edges later (R2), strobe low DVL cycles (R3), coding (R7).
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                pend[i]  = 1'b0;
                sched[i] = 1'b0;
            end
            prev_cc  = 1'b0;
            last_acc = -100;
            exp_off  = '0;
            exp_tc   = '0;
            dvcnt    = 0;
        end else begin
            if (conv_clk && !prev_cc) pend[(cyc + 2) % N] = 1'b1;
            prev_cc = conv_clk;
            if (pend[cyc % N]) begin
                pend[cyc % N] = 1'b0;
                if (cyc - last_acc > GAP) begin
                    last_acc = cyc;
                    sched[(cyc + LAT) % N] = 1'b1;
                    sval[(cyc + LAT) % N]  = sample_in;
                end
            end
            if (sched[cyc % N]) begin
                sched[cyc % N] = 1'b0;
                exp_off = sval[cyc % N];
                exp_tc  = sval[cyc % N] ^ MSB;
                dvcnt   = DVL;
            end else if (dvcnt > 0) begin
                dvcnt--;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
        end
    endtask

    // Compare both instances with the model on every falling edge.
    always @(negedge clk) begin
        if (!finished) begin
            check(dout == exp_off, {tag, "/R2 data_out"}, dout, exp_off);
            check(dv == (dvcnt == 0), {tag, "/R3 data_valid"}, dv, dvcnt == 0);
            check(dout_tc == exp_tc, {tag, "/R7 twos data_out"}, dout_tc, exp_tc);
            check(dv_tc == (dvcnt == 0), {tag, "/R7 twos data_valid"}, dv_tc, dvcnt == 0);
        end
    end

    // One conversion-clock period: high for hi cycles, low for lo cycles.
    task automatic pulse(input logic [DW-1:0] v, input int hi, input int lo);
        @(negedge clk);
        sample_in = v;
        conv_clk  = 1'b1;
        repeat (hi) @(negedge clk);
        conv_clk = 1'b0;
        repeat (lo - 1) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R8: reset state
        tag = "R8";
        idle(5);
        rst_n = 1'b1;
        idle(3);

        // R1: isolated conversions sweep every code
        tag = "R1";
        for (int v = 0; v < (1 << DW); v++) pulse(DW'(v), 3, 10);
        idle(LAT + 5);

        // R4: periods from 2 to 6, short ones partly rejected
        tag = "R4";
        for (int p = 2; p <= 6; p++) begin
            for (int k = 0; k < 12; k++) pulse(DW'(p * 8 + k), 1, p - 1);
            idle(LAT + 5);
        end

        // R5: overlapping conversions with mixed spacing
        tag = "R5";
        for (int k = 0; k < 24; k++) pulse(DW'(k * 5 + 3), 2, 2 + (k % 4));
        idle(LAT + 5);

        // R6: long run at the minimum legal spacing, alternating extremes
        tag = "R6";
        for (int k = 0; k < 40; k++) pulse((k % 2) ? '1 : '0, 2, 2);
        idle(LAT + 5);

        // R8: reset with conversions in flight
        tag = "R8";
        for (int k = 0; k < 3; k++) pulse(DW'(k + 40), 2, 2);
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(LAT + 8);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL %s watchdog: actual %0d expected %0d", tag, 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule